// File: doc/BRIEF.md
# Monotonic Counter Region Guard

This block protects the lowest region of a serial memory array, the part organised as sixteen 16-bit counters that may only move upwards. The serial front-end hands it one decoded request per cycle: whether the opcode was the dedicated counter-write opcode or an ordinary write, the byte address, the 16-bit candidate value, the total number of serial clocks in the frame, and the state of the write-enable latch. For a legal counter write the guard fetches the stored word from the array, compares it against the candidate, and issues a commit only when the candidate is strictly larger. Every counter write it evaluates reports the comparison outcome on a status flag and asks the front-end to drop the write-enable latch. Ordinary writes that land in the counter region are refused outright.

The word storage and the serial shifting sit outside the block. The storage answers a read one cycle after it is requested and applies a commit at the clock edge on which the commit strobe is high. The write-protect pin and the block-protect bits of the status register have no input here, because the counter comparison applies whatever their setting.

Top module: `mono_counter_guard`

## Requirements
- R1: While reset is low and in the first cycle after it, `rdEn`, `wrEn`, `clearWel`, `plainDeny` and `incFlag` are all 0.
- R2: A legal counter write (`reqIncr`=1, address bit 0 clear, address below 0x020, `reqClocks` exactly 40, `wel`=1) raises `rdEn` for one cycle after the request edge, with `rdIdx` equal to address bits 4..1.
- R3: When the candidate of a legal counter write is strictly greater than the stored word, `wrEn` is high for one cycle two cycles after the request edge, with `wrIdx` the word index and `wrWord` the candidate; `reqWord` carries the first data byte in bits 15..8 and the second in bits 7..0.
- R4: When the candidate is equal to or lower than the stored word, no commit is issued and `incFlag` becomes 1; after an accepted write `incFlag` is 0.
- R5: A counter write whose frame is not exactly 40 clocks reads nothing, commits nothing, leaves `incFlag` unchanged and does not raise `clearWel`.
- R6: A counter write to an odd byte address is ignored in the same way as R5.
- R7: A counter write while `wel`=0 is ignored in the same way as R5.
- R8: `clearWel` pulses for one cycle in the cycle the decision of each legal counter write appears, whether the write was accepted or refused.
- R9: An ordinary write (`reqIncr`=0) to an address below 0x020 raises `plainDeny` for one cycle after the request edge and starts no read; one at or above 0x020 leaves `plainDeny` low.
- R10: A counter-write opcode aimed at an address at or above 0x020 is ignored in the same way as R5.
- R11: Requests to the same counter on consecutive cycles are each compared against the newest value, including a commit issued one or two cycles earlier that the storage has not yet returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A decoded write request is present this cycle |
| reqIncr | input | 1 | 1 = counter-write opcode, 0 = ordinary write |
| reqAddr | input | 10 | Byte address of the request |
| reqWord | input | 16 | Candidate value, first data byte in the upper half |
| reqClocks | input | 9 | Serial clocks counted over the whole frame |
| wel | input | 1 | Current write-enable latch state |
| rdEn | output | 1 | Read strobe to the word storage |
| rdIdx | output | 4 | Counter index to read |
| rdWord | input | 16 | Stored word, valid one cycle after `rdEn` |
| wrEn | output | 1 | Commit strobe to the word storage |
| wrIdx | output | 4 | Counter index to commit |
| wrWord | output | 16 | Value to commit |
| incFlag | output | 1 | Comparator status: 1 = last candidate not greater |
| clearWel | output | 1 | Pulse asking the front-end to reset the latch |
| plainDeny | output | 1 | Pulse: ordinary write to the counter region refused |

## Verification
The comparison of one request and the commit of the previous request to the same counter can land in the same cycle, and so can a comparison and a commit issued two cycles earlier, before the storage reflects either. The bench provokes both by issuing three requests to one counter on consecutive cycles, with values chosen so that a comparison against the stale stored word would accept what the newest value must refuse. Each decision is judged against a reference array the bench updates only from the requirements.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

  // Strobes the control path hands to the datapath each cycle.
  typedef struct packed {
    logic capture;  // latch a legal counter-write request
    logic advance;  // move the pending request to the compare stage
    logic decide;   // compare and produce the verdict
  } guard_strobe_t;

endpackage

// File: rtl/mcg_ctrl.sv
module mcg_ctrl
  import mcg_pkg::*;
#(
  parameter int WORDS      = 16,
  parameter int ADDR_W     = 10,
  parameter int CNT_W      = 9,
  parameter int FRAME_CLKS = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIncr,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqClocks,
  input  logic              wel,
  output guard_strobe_t     strobe,
  output logic              rdEn,
  output logic              plainDeny
);

  localparam int REGION_BYTES = WORDS * 2;

  logic inRegion;
  logic exactLen;
  logic evenAddr;
  logic formed;
  logic s1Live;
  logic s2Live;

  assign inRegion = reqAddr < ADDR_W'(REGION_BYTES);
  assign exactLen = reqClocks == CNT_W'(FRAME_CLKS);
  assign evenAddr = ~reqAddr[0];
  assign formed   = reqValid & reqIncr & evenAddr & inRegion & exactLen & wel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Live    <= 1'b0;
      s2Live    <= 1'b0;
      plainDeny <= 1'b0;
    end else begin
      s1Live    <= formed;
      s2Live    <= s1Live;
      plainDeny <= reqValid & ~reqIncr & inRegion;
    end
  end

  assign rdEn = s1Live;

  always_comb begin
    strobe.capture = formed;
    strobe.advance = s1Live;
    strobe.decide  = s2Live;
  end

endmodule

// File: rtl/mcg_datapath.sv
module mcg_datapath
  import mcg_pkg::*;
#(
  parameter int WORDS  = 16,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  guard_strobe_t            strobe,
  input  logic [$clog2(WORDS)-1:0] reqIdx,
  input  logic [WORD_W-1:0]        reqWord,
  input  logic [WORD_W-1:0]        rdWord,
  output logic [$clog2(WORDS)-1:0] rdIdx,
  output logic                     wrEn,
  output logic [$clog2(WORDS)-1:0] wrIdx,
  output logic [WORD_W-1:0]        wrWord,
  output logic                     incFlag,
  output logic                     clearWel
);

  localparam int IDX_W = $clog2(WORDS);

  logic [IDX_W-1:0]  s1Idx, s2Idx;
  logic [WORD_W-1:0] s1Cand, s2Cand;
  logic              prevEn;
  logic [IDX_W-1:0]  prevIdx;
  logic [WORD_W-1:0] prevWord;
  logic [WORD_W-1:0] stored;
  logic              greater;

  // Request pipeline: capture, then hold for the compare stage.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Idx  <= '0;
      s1Cand <= '0;
      s2Idx  <= '0;
      s2Cand <= '0;
    end else begin
      if (strobe.capture) begin
        s1Idx  <= reqIdx;
        s1Cand <= reqWord;
      end
      if (strobe.advance) begin
        s2Idx  <= s1Idx;
        s2Cand <= s1Cand;
      end
    end
  end

  assign rdIdx = s1Idx;

  // Newest value of the counter: the commit leaving this cycle wins over
  // the one from the cycle before, which wins over the storage read.
  always_comb begin
    stored = rdWord;
    if (prevEn && prevIdx == s2Idx) stored = prevWord;
    if (wrEn && wrIdx == s2Idx)     stored = wrWord;
  end

  assign greater = s2Cand > stored;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn     <= 1'b0;
      wrIdx    <= '0;
      wrWord   <= '0;
      incFlag  <= 1'b0;
      clearWel <= 1'b0;
      prevEn   <= 1'b0;
      prevIdx  <= '0;
      prevWord <= '0;
    end else begin
      prevEn   <= wrEn;
      prevIdx  <= wrIdx;
      prevWord <= wrWord;
      wrEn     <= strobe.decide & greater;
      clearWel <= strobe.decide;
      if (strobe.decide) begin
        incFlag <= ~greater;
        if (greater) begin
          wrIdx  <= s2Idx;
          wrWord <= s2Cand;
        end
      end
    end
  end

endmodule

// File: rtl/mono_counter_guard.sv
module mono_counter_guard
  import mcg_pkg::*;
#(
  parameter int WORDS      = 16,
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 10,
  parameter int CNT_W      = 9,
  parameter int FRAME_CLKS = 40
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqIncr,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [WORD_W-1:0]        reqWord,
  input  logic [CNT_W-1:0]         reqClocks,
  input  logic                     wel,
  output logic                     rdEn,
  output logic [$clog2(WORDS)-1:0] rdIdx,
  input  logic [WORD_W-1:0]        rdWord,
  output logic                     wrEn,
  output logic [$clog2(WORDS)-1:0] wrIdx,
  output logic [WORD_W-1:0]        wrWord,
  output logic                     incFlag,
  output logic                     clearWel,
  output logic                     plainDeny
);

  localparam int IDX_W = $clog2(WORDS);

  guard_strobe_t strobe;

  mcg_ctrl #(
    .WORDS(WORDS), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FRAME_CLKS(FRAME_CLKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIncr(reqIncr),
    .reqAddr(reqAddr), .reqClocks(reqClocks), .wel(wel),
    .strobe(strobe), .rdEn(rdEn), .plainDeny(plainDeny)
  );

  mcg_datapath #(
    .WORDS(WORDS), .WORD_W(WORD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqIdx(reqAddr[IDX_W:1]), .reqWord(reqWord), .rdWord(rdWord),
    .rdIdx(rdIdx), .wrEn(wrEn), .wrIdx(wrIdx), .wrWord(wrWord),
    .incFlag(incFlag), .clearWel(clearWel)
  );

endmodule

// File: rtl/mcg_checker.sv
module mcg_checker #(
  parameter int WORDS      = 16,
  parameter int ADDR_W     = 10,
  parameter int CNT_W      = 9,
  parameter int FRAME_CLKS = 40
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     reqValid,
  input logic                     reqIncr,
  input logic [ADDR_W-1:0]        reqAddr,
  input logic [CNT_W-1:0]         reqClocks,
  input logic                     wel,
  input logic                     rdEn,
  input logic [$clog2(WORDS)-1:0] rdIdx,
  input logic                     wrEn,
  input logic                     incFlag,
  input logic                     clearWel,
  input logic                     plainDeny
);

  localparam int IDX_W = $clog2(WORDS);
  localparam int REGION_BYTES = WORDS * 2;

  logic legalReq;
  assign legalReq = reqValid && reqIncr && !reqAddr[0] && wel &&
                    (reqAddr < ADDR_W'(REGION_BYTES)) &&
                    (reqClocks == CNT_W'(FRAME_CLKS));

  p_quiet_reset_r1: assert property (@(posedge clk)
    !rstN |=> (!wrEn && !rdEn && !clearWel && !plainDeny && !incFlag));

  p_read_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    legalReq |=> (rdEn && rdIdx == $past(reqAddr[IDX_W:1])));

  p_write_after_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(rdEn, 2));

  p_flag_on_accept_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !incFlag);

  p_frame_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqIncr && reqClocks != CNT_W'(FRAME_CLKS)) |=> !rdEn);

  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !clearWel |-> $stable(incFlag));

  p_clear_with_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> clearWel);

  p_plain_no_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqIncr) |=> !rdEn);

endmodule

bind mono_counter_guard mcg_checker #(
  .WORDS(WORDS), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FRAME_CLKS(FRAME_CLKS)
) u_mcg_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIncr(reqIncr),
  .reqAddr(reqAddr), .reqClocks(reqClocks), .wel(wel), .rdEn(rdEn),
  .rdIdx(rdIdx), .wrEn(wrEn), .incFlag(incFlag), .clearWel(clearWel),
  .plainDeny(plainDeny)
);

// File: tb/test_mono_counter_guard.sv
`timescale 1ns/1ps
module test_mono_counter_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqIncr = 1'b0;
  logic [9:0]  reqAddr = '0;
  logic [15:0] reqWord = '0;
  logic [8:0]  reqClocks = '0;
  logic        wel = 1'b0;
  logic        rdEn;
  logic [3:0]  rdIdx;
  logic [15:0] rdWord;
  logic        wrEn;
  logic [3:0]  wrIdx;
  logic [15:0] wrWord;
  logic        incFlag;
  logic        clearWel;
  logic        plainDeny;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] storeMem [16];
  logic [15:0] refMem [16];
  logic        flagRef = 1'b0;

  always #2.5 clk = ~clk;

  mono_counter_guard i_mono_counter_guard (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIncr(reqIncr),
    .reqAddr(reqAddr), .reqWord(reqWord), .reqClocks(reqClocks), .wel(wel),
    .rdEn(rdEn), .rdIdx(rdIdx), .rdWord(rdWord), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrWord(wrWord), .incFlag(incFlag), .clearWel(clearWel),
    .plainDeny(plainDeny)
  );

  // Word storage model: one-cycle read latency, read sees the old value.
  initial begin
    for (int i = 0; i < 16; i++) begin
      storeMem[i] = '0;
      refMem[i]   = '0;
    end
  end
  always_ff @(posedge clk) begin
    if (rdEn) rdWord <= storeMem[rdIdx];
    if (wrEn) storeMem[wrIdx] <= wrWord;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One counter-write request, checked through read, verdict and commit.
  task automatic runIncr(input logic [9:0] addr, input logic [15:0] cand,
                         input logic [8:0] clocks, input logic welV, input string tag);
    logic [3:0] idx;
    bit eval;
    bit wr;
    idx  = addr[4:1];
    eval = (addr[0] == 1'b0) && (addr < 10'h20) && (clocks == 9'd40) && welV;
    wr   = eval && (cand > refMem[idx]);
    @(negedge clk);
    reqValid = 1'b1; reqIncr = 1'b1; reqAddr = addr; reqWord = cand;
    reqClocks = clocks; wel = welV;
    @(negedge clk);
    reqValid = 1'b0;
    check(rdEn == eval, {tag, " R2 read strobe"}, rdEn, eval);
    if (eval) check(rdIdx == idx, {tag, " R2 read index"}, rdIdx, idx);
    @(negedge clk);
    @(negedge clk);
    check(wrEn == wr, {tag, " R3/R4 commit"}, wrEn, wr);
    check(clearWel == eval, {tag, " R8 latch clear"}, clearWel, eval);
    if (wr) begin
      check(wrWord == cand, {tag, " R3 commit word"}, wrWord, cand);
      check(wrIdx == idx, {tag, " R3 commit index"}, wrIdx, idx);
      refMem[idx] = cand;
    end
    if (eval) flagRef = !wr;
    check(incFlag == flagRef, {tag, " R4/R5 comparator flag"}, incFlag, flagRef);
    @(negedge clk);
  endtask

  task automatic testReset();
    check(!rdEn && !wrEn && !clearWel && !plainDeny && !incFlag, "R1 reset outputs",
          {rdEn, wrEn, clearWel, plainDeny, incFlag}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!rdEn && !wrEn && !clearWel && !plainDeny && !incFlag, "R1 after release",
          {rdEn, wrEn, clearWel, plainDeny, incFlag}, 0);
  endtask

  task automatic testPlain(input logic [9:0] addr, input string tag);
    bit deny;
    deny = addr < 10'h20;
    @(negedge clk);
    reqValid = 1'b1; reqIncr = 1'b0; reqAddr = addr; reqWord = 16'hFFFF;
    reqClocks = 9'd32; wel = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(plainDeny == deny, {tag, " R9 plain deny"}, plainDeny, deny);
    check(!rdEn, {tag, " R9 no read"}, rdEn, 0);
    @(negedge clk);
    check(!plainDeny, {tag, " R9 single pulse"}, plainDeny, 0);
    @(negedge clk);
    @(negedge clk);
    check(!wrEn && !clearWel, {tag, " R9 no commit"}, {wrEn, clearWel}, 0);
  endtask

  // R11: three back-to-back requests to one counter.
  task automatic testBackToBack();
    logic [15:0] vals [3];
    bit expW [3];
    logic [15:0] cur;
    vals[0] = 16'h0900; vals[1] = 16'h0700; vals[2] = 16'h0800;
    cur = refMem[9];
    for (int k = 0; k < 3; k++) begin
      expW[k] = vals[k] > cur;
      if (expW[k]) cur = vals[k];
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      reqValid = 1'b1; reqIncr = 1'b1; reqAddr = 10'h012; reqWord = vals[k];
      reqClocks = 9'd40; wel = 1'b1;
    end
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(wrEn == expW[k], "R11 back-to-back verdict", wrEn, expW[k]);
      check(incFlag == !expW[k], "R11 back-to-back flag", incFlag, !expW[k]);
      check(clearWel, "R8 back-to-back latch clear", clearWel, 1);
      @(negedge clk);
    end
    refMem[9] = cur;
    flagRef = !expW[2];
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    runIncr(10'h004, 16'h0100, 9'd40, 1'b1, "accept");
    runIncr(10'h004, 16'h0100, 9'd40, 1'b1, "equal");
    runIncr(10'h004, 16'h00FF, 9'd40, 1'b1, "lower");
    runIncr(10'h004, 16'h0101, 9'd40, 1'b1, "one above");
    runIncr(10'h006, 16'h0A00, 9'd40, 1'b1, "second word");
    runIncr(10'h006, 16'h09FF, 9'd40, 1'b1, "high byte decides R3");
    runIncr(10'h008, 16'h0050, 9'd39, 1'b1, "short frame R5");
    runIncr(10'h008, 16'h0050, 9'd41, 1'b1, "long frame R5");
    runIncr(10'h005, 16'h0050, 9'd40, 1'b1, "odd address R6");
    runIncr(10'h008, 16'h0050, 9'd40, 1'b0, "latch clear R7");
    runIncr(10'h040, 16'h0050, 9'd40, 1'b1, "outside region R10");
    runIncr(10'h01E, 16'hFFFF, 9'd40, 1'b1, "top word max");
    runIncr(10'h01E, 16'hFFFF, 9'd40, 1'b1, "top word repeat");
    testPlain(10'h010, "plain inside");
    testPlain(10'h100, "plain outside");
    runIncr(10'h012, 16'h0003, 9'd40, 1'b1, "seed word 9");
    testBackToBack();
    for (int i = 0; i < 16; i++)
      check(storeMem[i] == refMem[i], "R3/R11 final contents", storeMem[i], refMem[i]);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule